// File: doc/BRIEF.md
# Raw and Masked Interrupt Status Unit

This unit gathers single-cycle hardware event pulses from two groups, a 15-bit main group and a 5-bit message group. The message group has four legacy interrupt lines and one message-signalled line. Each group keeps three registers: a raw status register, a masked status register and an enable vector. The raw register records every event. The masked register records an event only when its enable bit is set. The two status views are cross-coupled. A software write of 1 to a raw bit also sets the masked bit. A software write of 1 to a masked bit also clears the raw bit. Enables are changed through a write-one-to-set word and a write-one-to-clear word, and both words read back the same vector.

Each group drives two interrupt outputs, and the integrator connects whichever one the system needs:

- The level output is high while any masked bit of the group is set.
- The pulsed output is driven by a small state machine per group, with three states:
  - `PS_ARMED` moves to `PS_FIRE` when the group's masked status is nonzero.
  - `PS_FIRE` drives the pulse for exactly one cycle, then always moves to `PS_HOLD`.
  - `PS_HOLD` stays silent until an end-of-interrupt write names the group. On that write it moves to `PS_FIRE` if anything is still pending, and back to `PS_ARMED` if nothing is pending.

Software reaches the unit over a plain 32-bit register bus. Writes take effect at the clock edge. Reads are combinational from `bus_addr`.

Top module: `irq_status_unit`

## Requirements
- R1: Word offsets are: 0x00 end-of-interrupt, 0x04 main raw, 0x08 main masked, 0x0C main enable-set, 0x10 main enable-clear, 0x14 message raw, 0x18 message masked, 0x1C message enable-set, 0x20 message enable-clear. After reset every register reads 0 and all four interrupt outputs are low.
- R2: An event pulse sets its raw bit whether or not the bit is enabled. It sets its masked bit only when the enable bit is 1.
- R3: Writing 1 to a raw bit sets both the raw bit and the masked bit. Writing 0 to a raw bit changes nothing.
- R4: Writing 1 to a masked bit clears both the masked bit and the raw bit.
- R5: Writing 1 to a bit at the enable-set word sets that enable bit. Writing 1 to a bit at the enable-clear word clears it. Both words read the same current enable vector.
- R6: Main bits 7:6 and 31:15 always read 0, and message bits 31:5 always read 0. Writes of 1 to these bits leave them at 0.
- R7: A group's level output equals the OR of that group's masked bits. End-of-interrupt writes do not change it.
- R8: When a group's masked status becomes nonzero while its machine is armed, the group's pulsed output is high for exactly one cycle, starting one clock after the status change.
- R9: After a pulse the pulsed output stays low until an end-of-interrupt write names that group. On that write it pulses at once if a masked bit is still set; otherwise the machine re-arms and waits for the next nonzero status. An end-of-interrupt write made during the pulse cycle itself is ignored.
- R10: At offset 0x00, writing 0 ends the interrupt on the main group and writing 1 ends it on the message group. Any other value has no effect. Offset 0x00 always reads 0.
- R11: If an event and a masked-status clear hit the same bit in the same cycle, the event wins. The raw bit stays set, and the masked bit stays set when the bit is enabled.
- R12: A masked bit is never set while its raw bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_evt | input | 15 | Main-group event pulses |
| msg_evt | input | 5 | Message-group event pulses |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| main_irq_level | output | 1 | Main-group level interrupt |
| main_irq_pulse | output | 1 | Main-group pulsed interrupt |
| msg_irq_level | output | 1 | Message-group level interrupt |
| msg_irq_pulse | output | 1 | Message-group pulsed interrupt |

## Verification
A status bit that is wrongly set or lost shows at the level output in the cycle after the offending edge. It also shows on a read of either status word, because the raw and masked views are coupled. A pulse machine stuck in the wrong state shows up as a missing or repeated pulse:

- It shows one clock after the status becomes nonzero, when the machine should leave the armed state.
- It shows in the very cycle after an end-of-interrupt write, when the machine should leave the hold state.

The bench therefore samples the pulsed outputs cycle by cycle around each of these edges, rather than only at the end of a sequence.

// File: rtl/isu_pkg.sv
package isu_pkg;

    localparam int unsigned MAIN_W    = 15;
    localparam int unsigned MSG_W     = 5;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned GROUPS    = 2;

    // main bits 7:6 are reserved
    localparam logic [MAIN_W-1:0] MAIN_MASK = 15'h7F3F;
    localparam logic [MSG_W-1:0]  MSG_MASK  = 5'h1F;

    // word index = byte address / 4
    typedef enum logic [3:0] {
        REG_EOI       = 4'd0,
        REG_MAIN_RAW  = 4'd1,
        REG_MAIN_MSK  = 4'd2,
        REG_MAIN_ENS  = 4'd3,
        REG_MAIN_ENC  = 4'd4,
        REG_MSG_RAW   = 4'd5,
        REG_MSG_MSK   = 4'd6,
        REG_MSG_ENS   = 4'd7,
        REG_MSG_ENC   = 4'd8
    } isu_reg_e;

    typedef enum logic [1:0] {
        PS_ARMED = 2'd0,
        PS_FIRE  = 2'd1,
        PS_HOLD  = 2'd2
    } pulse_state_e;

    localparam int unsigned GRP_MAIN = 0;
    localparam int unsigned GRP_MSG  = 1;

endpackage

// File: rtl/isu_reg_decode.sv
module isu_reg_decode
    import isu_pkg::*;
#(
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          main_raw_we,
    output logic          main_msk_we,
    output logic          main_ens_we,
    output logic          main_enc_we,
    output logic          msg_raw_we,
    output logic          msg_msk_we,
    output logic          msg_ens_we,
    output logic          msg_enc_we,
    output logic          eoi_main,
    output logic          eoi_msg,
    output logic          addr_ok,
    output isu_reg_e      reg_sel
);

    localparam int unsigned IDX_LO = 2;
    localparam int unsigned IDX_HI = 5;

    logic [IDX_HI-IDX_LO:0] idx;
    logic                   wr_hit;

    always_comb begin
        idx     = bus_addr[IDX_HI:IDX_LO];
        addr_ok = (bus_addr[AW-1:IDX_HI+1] == '0) && (bus_addr[IDX_LO-1:0] == '0)
                  && (idx <= REG_MSG_ENC);
        reg_sel = isu_reg_e'(idx);
        wr_hit  = bus_wr && addr_ok;
    end

    always_comb begin
        main_raw_we = wr_hit && (reg_sel == REG_MAIN_RAW);
        main_msk_we = wr_hit && (reg_sel == REG_MAIN_MSK);
        main_ens_we = wr_hit && (reg_sel == REG_MAIN_ENS);
        main_enc_we = wr_hit && (reg_sel == REG_MAIN_ENC);
        msg_raw_we  = wr_hit && (reg_sel == REG_MSG_RAW);
        msg_msk_we  = wr_hit && (reg_sel == REG_MSG_MSK);
        msg_ens_we  = wr_hit && (reg_sel == REG_MSG_ENS);
        msg_enc_we  = wr_hit && (reg_sel == REG_MSG_ENC);
        eoi_main    = wr_hit && (reg_sel == REG_EOI) && (bus_wdata == DW'(0));
        eoi_msg     = wr_hit && (reg_sel == REG_EOI) && (bus_wdata == DW'(1));
    end

endmodule

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
    parameter int unsigned W    = 15,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         raw_we,
    input  logic         msk_we,
    input  logic         ens_we,
    input  logic         enc_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] raw_q,
    output logic [W-1:0] msk_q,
    output logic [W-1:0] en_q
);

    logic [W-1:0] sw_set;
    logic [W-1:0] sw_clr;
    logic [W-1:0] evt_on;
    logic [W-1:0] raw_d;
    logic [W-1:0] msk_d;
    logic [W-1:0] en_d;

    always_comb begin
        sw_set = raw_we ? wdata : '0;
        sw_clr = msk_we ? wdata : '0;
        evt_on = evt & en_q;
        // an event in the same cycle overrides a software clear
        raw_d  = ((raw_q | evt    | sw_set) & ~(sw_clr & ~evt))    & MASK;
        msk_d  = ((msk_q | evt_on | sw_set) & ~(sw_clr & ~evt_on)) & MASK;
        en_d   = en_q;
        if (ens_we) en_d = en_d | wdata;
        if (enc_we) en_d = en_d & ~wdata;
        en_d   = en_d & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= '0;
            msk_q <= '0;
            en_q  <= '0;
        end else begin
            raw_q <= raw_d;
            msk_q <= msk_d;
            en_q  <= en_d;
        end
    end

endmodule

// File: rtl/isu_pulse_fsm.sv
module isu_pulse_fsm
    import isu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic eoi,
    output logic pulse
);

    pulse_state_e state_q;
    pulse_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_ARMED: if (pending) state_d = PS_FIRE;
            PS_FIRE:  state_d = PS_HOLD;
            PS_HOLD:  if (eoi) state_d = pending ? PS_FIRE : PS_ARMED;
            default:  state_d = PS_ARMED;
        endcase
    end

    always_comb begin
        pulse = (state_q == PS_FIRE);
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import isu_pkg::*;
#(
    parameter int unsigned        MW    = MAIN_W,
    parameter int unsigned        SW    = MSG_W,
    parameter int unsigned        AW    = ADDR_W,
    parameter int unsigned        DW    = DATA_W,
    parameter logic [MAIN_W-1:0]  MMASK = MAIN_MASK,
    parameter logic [MSG_W-1:0]   SMASK = MSG_MASK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [MW-1:0] main_evt,
    input  logic [SW-1:0] msg_evt,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          main_irq_level,
    output logic          main_irq_pulse,
    output logic          msg_irq_level,
    output logic          msg_irq_pulse
);

    logic main_raw_we, main_msk_we, main_ens_we, main_enc_we;
    logic msg_raw_we, msg_msk_we, msg_ens_we, msg_enc_we;
    logic eoi_main, eoi_msg, addr_ok;
    isu_reg_e reg_sel;

    logic [MW-1:0] main_raw_q, main_msk_q, main_en_q;
    logic [SW-1:0] msg_raw_q, msg_msk_q, msg_en_q;

    logic [GROUPS-1:0] grp_pending;
    logic [GROUPS-1:0] grp_eoi;
    logic [GROUPS-1:0] grp_pulse;

    isu_reg_decode #(.AW(AW), .DW(DW)) u_dec (
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .main_raw_we (main_raw_we),
        .main_msk_we (main_msk_we),
        .main_ens_we (main_ens_we),
        .main_enc_we (main_enc_we),
        .msg_raw_we  (msg_raw_we),
        .msg_msk_we  (msg_msk_we),
        .msg_ens_we  (msg_ens_we),
        .msg_enc_we  (msg_enc_we),
        .eoi_main    (eoi_main),
        .eoi_msg     (eoi_msg),
        .addr_ok     (addr_ok),
        .reg_sel     (reg_sel)
    );

    isu_status_bank #(.W(MW), .MASK(MMASK)) u_main (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (main_evt),
        .raw_we (main_raw_we),
        .msk_we (main_msk_we),
        .ens_we (main_ens_we),
        .enc_we (main_enc_we),
        .wdata  (bus_wdata[MW-1:0]),
        .raw_q  (main_raw_q),
        .msk_q  (main_msk_q),
        .en_q   (main_en_q)
    );

    isu_status_bank #(.W(SW), .MASK(SMASK)) u_msg (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (msg_evt),
        .raw_we (msg_raw_we),
        .msk_we (msg_msk_we),
        .ens_we (msg_ens_we),
        .enc_we (msg_enc_we),
        .wdata  (bus_wdata[SW-1:0]),
        .raw_q  (msg_raw_q),
        .msk_q  (msg_msk_q),
        .en_q   (msg_en_q)
    );

    always_comb begin
        grp_pending[GRP_MAIN] = |main_msk_q;
        grp_pending[GRP_MSG]  = |msg_msk_q;
        grp_eoi[GRP_MAIN]     = eoi_main;
        grp_eoi[GRP_MSG]      = eoi_msg;
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_pulse
        isu_pulse_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .pending (grp_pending[g]),
            .eoi     (grp_eoi[g]),
            .pulse   (grp_pulse[g])
        );
    end

    always_comb begin
        main_irq_level = grp_pending[GRP_MAIN];
        msg_irq_level  = grp_pending[GRP_MSG];
        main_irq_pulse = grp_pulse[GRP_MAIN];
        msg_irq_pulse  = grp_pulse[GRP_MSG];
    end

    always_comb begin
        bus_rdata = '0;
        if (addr_ok) begin
            unique case (reg_sel)
                REG_MAIN_RAW:               bus_rdata = DW'(main_raw_q);
                REG_MAIN_MSK:               bus_rdata = DW'(main_msk_q);
                REG_MAIN_ENS, REG_MAIN_ENC: bus_rdata = DW'(main_en_q);
                REG_MSG_RAW:                bus_rdata = DW'(msg_raw_q);
                REG_MSG_MSK:                bus_rdata = DW'(msg_msk_q);
                REG_MSG_ENS, REG_MSG_ENC:   bus_rdata = DW'(msg_en_q);
                default:                    bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/isu_checker.sv
module isu_checker
    import isu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [MAIN_W-1:0] main_evt,
    input logic              bus_wr,
    input logic [MAIN_W-1:0] main_raw,
    input logic [MAIN_W-1:0] main_msk,
    input logic [MAIN_W-1:0] main_en,
    input logic [MSG_W-1:0]  msg_raw,
    input logic [MSG_W-1:0]  msg_msk,
    input logic              main_pulse,
    input logic              msg_pulse
);

    logic [MAIN_W-1:0] evt_live;
    always_comb evt_live = main_evt & MAIN_MASK;

    AST_EVT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_live) |=> ((main_raw & $past(evt_live)) == $past(evt_live))); // R2

    AST_MAIN_MSK_IN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ((main_msk & ~main_raw) == '0)); // R12

    AST_MSG_MSK_IN_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        ((msg_msk & ~msg_raw) == '0)); // R12

    AST_MAIN_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        main_pulse |=> !main_pulse); // R8

    AST_MSG_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        msg_pulse |=> !msg_pulse); // R8

    AST_PULSE_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_pulse) |-> $past(|main_msk)); // R9

    AST_EN_HOLDS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(main_en)); // R5

endmodule

bind irq_status_unit isu_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .main_evt   (main_evt),
    .bus_wr     (bus_wr),
    .main_raw   (main_raw_q),
    .main_msk   (main_msk_q),
    .main_en    (main_en_q),
    .msg_raw    (msg_raw_q),
    .msg_msk    (msg_msk_q),
    .main_pulse (main_irq_pulse),
    .msg_pulse  (msg_irq_pulse)
);

// File: tb/tb_irq_status_unit.sv
module tb_irq_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] main_evt = '0;
    logic [4:0]  msg_evt = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        main_irq_level, main_irq_pulse, msg_irq_level, msg_irq_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_status_unit dut (
        .clk(clk), .rst_n(rst_n), .main_evt(main_evt), .msg_evt(msg_evt),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .main_irq_level(main_irq_level),
        .main_irq_pulse(main_irq_pulse), .msg_irq_level(msg_irq_level),
        .msg_irq_pulse(msg_irq_pulse)
    );

    // row: wr, addr, wdata, main_evt, msg_evt, read addr, expected read
    localparam int NV = 15;
    localparam logic [100:0] VECS [NV] = '{
        {1'b0, 8'h00, 32'h0,        15'h0001, 5'h00, 8'h04, 32'h0001}, // R2 raw without enable
        {1'b0, 8'h00, 32'h0,        15'h0000, 5'h00, 8'h08, 32'h0000}, // R2 masked stays clear
        {1'b1, 8'h0C, 32'h5,        15'h0000, 5'h00, 8'h10, 32'h0005}, // R5 set, read clear word
        {1'b0, 8'h00, 32'h0,        15'h0000, 5'h00, 8'h0C, 32'h0005}, // R5 read set word
        {1'b0, 8'h00, 32'h0,        15'h0004, 5'h00, 8'h08, 32'h0004}, // R2 enabled event
        {1'b1, 8'h04, 32'hFFFFFFFF, 15'h0000, 5'h00, 8'h04, 32'h7F3F}, // R3 R6 raw set
        {1'b0, 8'h00, 32'h0,        15'h0000, 5'h00, 8'h08, 32'h7F3F}, // R3 masked follows
        {1'b1, 8'h08, 32'h0F00,     15'h0000, 5'h00, 8'h04, 32'h703F}, // R4 clear hits raw
        {1'b1, 8'h04, 32'h0,        15'h0000, 5'h00, 8'h04, 32'h703F}, // R3 write 0 no effect
        {1'b1, 8'h10, 32'h1,        15'h0000, 5'h00, 8'h0C, 32'h0004}, // R5 clear word
        {1'b1, 8'h14, 32'hFF,       15'h0000, 5'h00, 8'h14, 32'h001F}, // R6 message width
        {1'b1, 8'h18, 32'h1F,       15'h0000, 5'h00, 8'h14, 32'h0000}, // R4 message group
        {1'b1, 8'h1C, 32'h12,       15'h0000, 5'h00, 8'h20, 32'h0012}, // R5 message enables
        {1'b0, 8'h00, 32'h0,        15'h0000, 5'h03, 8'h18, 32'h0002}, // R2 message masked
        {1'b1, 8'h00, 32'h1,        15'h0000, 5'h00, 8'h00, 32'h0000}  // R10 reads 0
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ev(input logic [14:0] m, input logic [4:0] s);
        @(negedge clk);
        main_evt = m; msg_evt = s;
        @(negedge clk);
        main_evt = '0; msg_evt = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        for (int a = 0; a <= 32; a += 4) rd_chk("R1 reset read", 8'(a), 32'h0);
        chk("R1 reset outputs", {28'h0, main_irq_level, main_irq_pulse, msg_irq_level, msg_irq_pulse}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_wr = VECS[i][100]; bus_addr = VECS[i][99:92]; bus_wdata = VECS[i][91:60];
            main_evt = VECS[i][59:45]; msg_evt = VECS[i][44:40];
            @(negedge clk);
            bus_wr = 1'b0; bus_wdata = '0; main_evt = '0; msg_evt = '0;
            rd_chk($sformatf("table row %0d", i), VECS[i][39:32], VECS[i][31:0]);
        end

        // return to a clean, armed state
        do_wr(8'h08, 32'hFFFF); do_wr(8'h18, 32'h1F);
        do_wr(8'h10, 32'hFFFF); do_wr(8'h20, 32'h1F);
        do_wr(8'h00, 32'h0);    do_wr(8'h00, 32'h1);
        chk("R7 level low after clear", {30'h0, main_irq_level, msg_irq_level}, 32'h0);

        // R8 first pulse
        do_wr(8'h0C, 32'h1);
        ev(15'h1, 5'h0);
        chk("R8 no pulse yet", {31'h0, main_irq_pulse}, 32'h0);
        chk("R7 level up", {31'h0, main_irq_level}, 32'h1);
        @(negedge clk); chk("R8 pulse high", {31'h0, main_irq_pulse}, 32'h1);
        @(negedge clk); chk("R8 pulse one cycle", {31'h0, main_irq_pulse}, 32'h0);

        // R9 silent until end-of-interrupt
        ev(15'h1, 5'h0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); chk("R9 silent in hold", {31'h0, main_irq_pulse}, 32'h0);
        end
        do_wr(8'h00, 32'h0);
        chk("R9 pulse on eoi with pending", {31'h0, main_irq_pulse}, 32'h1);
        @(negedge clk); chk("R9 eoi pulse one cycle", {31'h0, main_irq_pulse}, 32'h0);

        // R10 other line values leave main alone
        do_wr(8'h00, 32'h1);
        chk("R10 msg eoi no main pulse", {31'h0, main_irq_pulse}, 32'h0);
        chk("R7 level kept across eoi", {31'h0, main_irq_level}, 32'h1);
        do_wr(8'h00, 32'h2);
        chk("R10 value 2 no pulse", {31'h0, main_irq_pulse}, 32'h0);
        @(negedge clk); chk("R10 still silent", {31'h0, main_irq_pulse}, 32'h0);

        // R9 re-arm when nothing pending
        do_wr(8'h08, 32'h1);
        chk("R7 level drops", {31'h0, main_irq_level}, 32'h0);
        do_wr(8'h00, 32'h0);
        chk("R9 no pulse empty eoi", {31'h0, main_irq_pulse}, 32'h0);
        ev(15'h1, 5'h0);
        chk("R9 rearmed wait", {31'h0, main_irq_pulse}, 32'h0);
        @(negedge clk); chk("R9 rearmed pulse", {31'h0, main_irq_pulse}, 32'h1);

        // R11 event beats clear
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h1; main_evt = 15'h1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; main_evt = '0;
        rd_chk("R11 enabled bit kept", 8'h08, 32'h1);
        ev(15'h2, 5'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 32'h2; main_evt = 15'h2;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; main_evt = '0;
        rd_chk("R11 raw kept", 8'h04, 32'h3);
        rd_chk("R11 disabled masked", 8'h08, 32'h1);

        // R7 R8 message group
        do_wr(8'h1C, 32'h8);
        ev(15'h0, 5'h08);
        chk("R7 msg level", {31'h0, msg_irq_level}, 32'h1);
        @(negedge clk); chk("R8 msg pulse", {31'h0, msg_irq_pulse}, 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule